// File: doc/BRIEF.md
# Hardware A20 Gate Decoder

The block lives on the slave side of a keyboard-controller style host port. It watches host write cycles aimed at the first input data register, captured through the first chip select. Without firmware it decodes the two-byte sequence "command 0xD1, then a data byte" and drives an A20 address-mask pin from bit 1 of that data byte. The host write strobe is asynchronous to the slave clock. It is brought through a synchronizer, and its rising edge is found in the slave clock domain before any state changes.

A mode input selects who owns the pin. In fast mode the hardware decoder drives it. In regular mode a software-written output latch drives it, and firmware copies the decoded bit into that latch itself. A direction input gates the pin's output enable.

Top module: `a20_gate_ctrl`

## Requirements
- R1: After reset `a20_o` is 1 in both modes and the decoder is not armed.
- R2: With `fast_en_i`=1, `a20_o` follows the hardware decoder's output register. With `fast_en_i`=0 it follows the software output latch.
- R3: A cycle with `sw_we_i`=1 loads `sw_d_i` into the software latch. In regular mode the value shows on `a20_o` after the next clock edge.
- R4: A host write with `host_cmd_i`=1 (command) and data 0xD1, through select 0, arms the decoder.
- R5: A host data write (`host_cmd_i`=0) through select 0 while the decoder is armed sets the hardware output to bit 1 of the data byte (1 sets, 0 clears). The new value is visible no later than four slave clock edges after the strobe `host_wr_n_i` rises.
- R6: A command write with any value other than 0xD1 disarms the decoder, so a following data byte leaves the output unchanged.
- R7: A data write consumes the armed state. A second data byte without a new 0xD1 command leaves the output unchanged.
- R8: A data write while the decoder is not armed leaves the hardware output unchanged.
- R9: A write with `host_cs_n_i[0]`=1 is ignored, even if another select bit is low. It neither arms, disarms nor changes the output.
- R10: `a20_oe_o` equals `pin_dir_i`, the pin direction control (1 = output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_cs_n_i | input | NUM_CS | Host chip selects, active low; bit 0 reaches the decoded register |
| host_wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| host_cmd_i | input | 1 | Command/data select: 1 command, 0 data |
| host_data_i | input | DATA_W | Host write data |
| fast_en_i | input | 1 | 1 selects the hardware-decoded output |
| sw_we_i | input | 1 | Software latch write enable |
| sw_d_i | input | 1 | Software latch data |
| pin_dir_i | input | 1 | Pin direction, 1 = output |
| a20_o | output | 1 | A20 gate value |
| a20_oe_o | output | 1 | A20 pin output enable |

## Verification
A wrong armed state cannot be seen directly. It shows only at the next data write, where `a20_o` either takes a bit 1 it should ignore or keeps a value it should change. That happens within four clock edges of the strobe rising, and only in fast mode. The bench therefore follows every host write with a check of the pin. It mixes random command, data and select sequences with directed cases for a consumed arm, a non-0xD1 command, and a write through the wrong select. A corrupt software latch shows on the next cycle in regular mode.

// File: rtl/a20_gate_pkg.sv
package a20_gate_pkg;
  localparam logic [7:0] CMD_WR_OUTPORT = 8'hD1;
  localparam int         GATE_BIT       = 1;
  localparam logic       GATE_RST       = 1'b1;
endpackage

// File: rtl/host_wr_sync.sv
module host_wr_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_n_i,
  input  logic              sel_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_rise_o,
  output logic              cap_sel_o,
  output logic              cap_cmd_o,
  output logic [DATA_W-1:0] cap_data_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wr_n_i};
      prev_q <= sync_q[LAST];
    end
  end

  // bus is sampled while the synchronized strobe is still low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_sel_o  <= 1'b0;
      cap_cmd_o  <= 1'b0;
      cap_data_o <= '0;
    end else if (!sync_q[LAST]) begin
      cap_sel_o  <= sel_i;
      cap_cmd_o  <= cmd_i;
      cap_data_o <= data_i;
    end
  end

  assign wr_rise_o = sync_q[LAST] & ~prev_q;
endmodule

// File: rtl/a20_cmd_decoder.sv
module a20_cmd_decoder
  import a20_gate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_rise_i,
  input  logic              sel_i,
  input  logic              cmd_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              armed_o,
  output logic              gate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      gate_o  <= GATE_RST;
    end else if (wr_rise_i && sel_i) begin
      if (cmd_i) begin
        armed_o <= (data_i == DATA_W'(CMD_WR_OUTPORT));
      end else begin
        if (armed_o) gate_o <= data_i[GATE_BIT];
        armed_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/a20_gate_ctrl.sv
module a20_gate_ctrl
  import a20_gate_pkg::*;
#(
  parameter int NUM_CS      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CS-1:0] host_cs_n_i,
  input  logic              host_wr_n_i,
  input  logic              host_cmd_i,
  input  logic [DATA_W-1:0] host_data_i,
  input  logic              fast_en_i,
  input  logic              sw_we_i,
  input  logic              sw_d_i,
  input  logic              pin_dir_i,
  output logic              a20_o,
  output logic              a20_oe_o
);
  logic              wr_rise;
  logic              cap_sel;
  logic              cap_cmd;
  logic [DATA_W-1:0] cap_data;
  logic              armed;
  logic              hw_a20;
  logic              sw_a20_q;

  host_wr_sync #(.SYNC_STAGES(SYNC_STAGES), .DATA_W(DATA_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_n_i     (host_wr_n_i),
    .sel_i      (~host_cs_n_i[0]),
    .cmd_i      (host_cmd_i),
    .data_i     (host_data_i),
    .wr_rise_o  (wr_rise),
    .cap_sel_o  (cap_sel),
    .cap_cmd_o  (cap_cmd),
    .cap_data_o (cap_data)
  );

  a20_cmd_decoder #(.DATA_W(DATA_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_rise_i (wr_rise),
    .sel_i     (cap_sel),
    .cmd_i     (cap_cmd),
    .data_i    (cap_data),
    .armed_o   (armed),
    .gate_o    (hw_a20)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sw_a20_q <= GATE_RST;
    else if (sw_we_i) sw_a20_q <= sw_d_i;
  end

  assign a20_o    = fast_en_i ? hw_a20 : sw_a20_q;
  assign a20_oe_o = pin_dir_i;
endmodule

// File: rtl/a20_gate_chk.sv
module a20_gate_chk
  import a20_gate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_rise,
  input logic              cap_sel,
  input logic              cap_cmd,
  input logic [DATA_W-1:0] cap_data,
  input logic              armed,
  input logic              hw_a20
);
  p_hold_no_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_rise |=> $stable(hw_a20) && $stable(armed));

  p_arm_on_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise && cap_sel && cap_cmd && cap_data == DATA_W'(CMD_WR_OUTPORT) |=> armed);

  p_disarm_other_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise && cap_sel && cap_cmd && cap_data != DATA_W'(CMD_WR_OUTPORT) |=> !armed);

  p_data_sets_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise && cap_sel && !cap_cmd && armed |=> hw_a20 == $past(cap_data[GATE_BIT]));

  p_data_consumes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise && cap_sel && !cap_cmd |=> !armed);

  p_wrong_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise && !cap_sel |=> $stable(armed) && $stable(hw_a20));
endmodule

bind a20_gate_ctrl a20_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_rise  (wr_rise),
  .cap_sel  (cap_sel),
  .cap_cmd  (cap_cmd),
  .cap_data (cap_data),
  .armed    (armed),
  .hw_a20   (hw_a20)
);

// File: tb/tb_a20_gate_ctrl.sv
`timescale 1ns/1ps
module tb_a20_gate_ctrl;
  localparam int NUM_CS = 2;
  localparam int DATA_W = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NUM_CS-1:0] host_cs_n_i = '1;
  logic              host_wr_n_i = 1'b1;
  logic              host_cmd_i = 1'b0;
  logic [DATA_W-1:0] host_data_i = '0;
  logic              fast_en_i = 1'b1;
  logic              sw_we_i = 1'b0;
  logic              sw_d_i = 1'b0;
  logic              pin_dir_i = 1'b1;
  logic              a20_o;
  logic              a20_oe_o;

  int total = 0;
  int bad = 0;
  logic m_armed, m_hw, m_sw;

  always #5 clk_i = ~clk_i;

  a20_gate_ctrl #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) dut (.*);

  task automatic check(input logic got, input logic exp, input string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic logic exp_pin();
    return fast_en_i ? m_hw : m_sw;
  endfunction

  // bench model of one host write
  function automatic void model_write(input logic [NUM_CS-1:0] cs_n, input logic cmd,
                                      input logic [7:0] d);
    if (cs_n[0]) return;
    if (cmd) m_armed = (d == 8'hD1);
    else begin
      if (m_armed) m_hw = d[1];
      m_armed = 1'b0;
    end
  endfunction

  task automatic host_write(input logic [NUM_CS-1:0] cs_n, input logic cmd, input logic [7:0] d);
    @(negedge clk_i);
    host_cs_n_i = cs_n; host_cmd_i = cmd; host_data_i = d;
    @(negedge clk_i) host_wr_n_i = 1'b0;
    repeat (3) @(negedge clk_i);
    host_wr_n_i = 1'b1;
    repeat (4) @(negedge clk_i);
    host_cs_n_i = '1; host_data_i = $urandom_range(0, 255);
    model_write(cs_n, cmd, d);
  endtask

  task automatic sw_write(input logic v);
    @(negedge clk_i) begin sw_we_i = 1'b1; sw_d_i = v; end
    @(negedge clk_i) sw_we_i = 1'b0;
    m_sw = v;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1a20));
    m_armed = 1'b0; m_hw = 1'b1; m_sw = 1'b1;
    repeat (3) @(negedge clk_i);
    check(a20_o, 1'b1, "R1 fast reset");
    fast_en_i = 1'b0; #1;
    check(a20_o, 1'b1, "R1 regular reset");
    fast_en_i = 1'b1;
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R1: a data write right after reset must not change the pin (not armed)
    host_write(2'b10, 1'b0, 8'h00);
    check(a20_o, 1'b1, "R1 unarmed after reset");

    host_write(2'b10, 1'b1, 8'hD1);
    host_write(2'b10, 1'b0, 8'h00);
    check(a20_o, 1'b0, "R4 R5 clear");
    host_write(2'b10, 1'b0, 8'h02);
    check(a20_o, 1'b0, "R7 consumed arm");
    host_write(2'b10, 1'b1, 8'hD1);
    host_write(2'b10, 1'b0, 8'hFD);
    check(a20_o, 1'b0, "R5 bit1 only");
    host_write(2'b10, 1'b1, 8'hD1);
    host_write(2'b10, 1'b0, 8'h02);
    check(a20_o, 1'b1, "R5 set");
    host_write(2'b10, 1'b1, 8'hD1);
    host_write(2'b10, 1'b1, 8'hD0);
    host_write(2'b10, 1'b0, 8'h00);
    check(a20_o, 1'b1, "R6 other cmd disarms");
    host_write(2'b01, 1'b1, 8'hD1);
    host_write(2'b10, 1'b0, 8'h00);
    check(a20_o, 1'b1, "R9 wrong select no arm");
    host_write(2'b10, 1'b1, 8'hD1);
    host_write(2'b00 | 2'b01, 1'b0, 8'h00);
    host_write(2'b10, 1'b0, 8'h00);
    check(a20_o, 1'b0, "R9 wrong select no disarm");
    host_write(2'b11, 1'b0, 8'h02);
    check(a20_o, 1'b0, "R8 no select");

    // R5 latency: pin changes no later than four edges after strobe rise
    host_write(2'b10, 1'b1, 8'hD1);
    @(negedge clk_i) begin host_cs_n_i = 2'b10; host_cmd_i = 1'b0; host_data_i = 8'h02; end
    @(negedge clk_i) host_wr_n_i = 1'b0;
    repeat (3) @(negedge clk_i);
    host_wr_n_i = 1'b1;
    @(negedge clk_i);
    check(a20_o, 1'b0, "R5 not before sync");
    repeat (3) @(negedge clk_i);
    check(a20_o, 1'b1, "R5 latency");
    host_cs_n_i = '1;
    m_hw = 1'b1; m_armed = 1'b0;

    // R2 R3: regular mode uses software latch
    fast_en_i = 1'b0;
    sw_write(1'b0);
    check(a20_o, 1'b0, "R3 sw latch clear");
    host_write(2'b10, 1'b1, 8'hD1);
    host_write(2'b10, 1'b0, 8'h02);
    check(a20_o, 1'b0, "R2 regular ignores hw");
    sw_write(1'b1);
    check(a20_o, 1'b1, "R3 sw latch set");
    sw_write(1'b0);
    fast_en_i = 1'b1; #1;
    check(a20_o, m_hw, "R2 fast selects hw");

    pin_dir_i = 1'b0; #1;
    check(a20_oe_o, 1'b0, "R10 dir in");
    pin_dir_i = 1'b1; #1;
    check(a20_oe_o, 1'b1, "R10 dir out");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [NUM_CS-1:0] cs;
      logic cmd;
      logic [7:0] d;
      cs  = ($urandom_range(0, 5) == 0) ? NUM_CS'($urandom_range(0, 3)) : 2'b10;
      cmd = $urandom_range(0, 1);
      d   = (cmd && $urandom_range(0, 2) != 0) ? 8'hD1 : 8'($urandom_range(0, 255));
      if ($urandom_range(0, 9) == 0) begin
        fast_en_i = ~fast_en_i;
        if ($urandom_range(0, 1) == 1) sw_write(logic'($urandom_range(0, 1)));
      end
      host_write(cs, cmd, d);
      check(a20_o, exp_pin(), cmd ? "R4 R6 random" : "R5 R7 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule